// File: doc/BRIEF.md
# Exception Control Register Bank

This block holds the system-control registers that sit beside the integer pipeline of a 32-bit RISC core. It decodes the coprocessor-0 move instructions that the core passes to it. It serves reads, masked writes and read-modify operations on a sparse set of registers. Each register is addressed by a 5-bit number and a 3-bit select.

When the core reports an exception, the block records two things. The first is the address at which execution must later resume. When the faulting instruction sat in a delay slot, that address is the branch before it. The second is the cause code together with a delay-slot flag. An exception-return instruction makes the block hand back the saved address as a PC redirect.

All results appear on registered outputs one clock after the instruction is presented. A read-modify operation therefore returns the value the register held before its own update.

Top module: `exc_ctrl_bank`

## Requirements
- R1: After reset every register reads zero, and `rd_valid`, `rd_data`, `fault`, `redirect_valid` and `redirect_pc` are all zero.
- R2: An instruction word has primary opcode 16 in bits 31:26 and sub-operation 0 in bits 25:21. Such a word, presented with `instr_valid`, is a move-from. The register number comes from bits 15:11 and the select from bits 2:0. One cycle later, `rd_valid` is 1 and `rd_data` holds the register's value.
- R3: Sub-operation 4 is a move-to. It stores (`src_operand` AND mask) OR (old AND NOT mask). The mask is all ones for user-local (4,2) and for exception PC (14,0), and 0xFFFFFFFC for exception base (15,1). The mask is zero for bad address (8,0), count (9,0), compare (11,0), status (12,0), cause (13,0) and config (16,0).
- R4: A move-from, move-to or read-modify to any other (number, select) pair leaves every register unchanged. One cycle later it raises `fault` for one cycle, with `rd_valid` at 0 and `rd_data` at 0.
- R5: Sub-operation 11 is a read-modify. It returns the old value like a move-from. It then writes `src_operand`, through the mask, with bit 0 forced to 1 when instruction bit 5 is 1 and forced to 0 otherwise.
- R6: On `exc_valid`, the exception PC register takes `exc_branch_pc` when `exc_in_slot` is 1 and `exc_pc` otherwise.
- R7: On `exc_valid`, cause bit 31 takes `exc_in_slot` and cause bits 6:0 are cleared. When `exc_code` is nonzero (code 0 is an interrupt), the code is then written into cause bits 6:2.
- R8: Sub-operations 16 to 31 with function bits 5:0 equal to 24 are an exception return. One cycle later `redirect_valid` is 1 for one cycle and `redirect_pc` holds the exception PC value.
- R9: If a software write and an exception update target the same register in one cycle, the exception update is kept.
- R10: Words with another primary opcode, other sub-operations or function codes, and any word presented with `instr_valid` low change no register and raise no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| src_operand | input | 32 | Source register operand for writes |
| exc_valid | input | 1 | Exception reported this cycle |
| exc_code | input | 5 | Exception cause code, 0 = interrupt |
| exc_in_slot | input | 1 | Faulting instruction was in a delay slot |
| exc_pc | input | 32 | Address of the faulting instruction |
| exc_branch_pc | input | 32 | Address of the branch owning the delay slot |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| fault | output | 1 | Access to an unmapped register pair |
| redirect_valid | output | 1 | Exception return redirect |
| redirect_pc | output | 32 | Redirect target |

## Verification
A corrupted register shows up only when the register is next read back, or in the case of the exception PC, at the next exception return. The bench therefore follows every write or exception with a read of the affected register, one cycle later on `rd_data` or `redirect_pc`. A mis-decoded map entry shows as a `fault` pulse, or as a missing one, in the cycle after the access. The same read-back exposes a wrong mask, because bits that should be frozen come back changed.

// File: rtl/xcb_pkg.sv
package xcb_pkg;

   localparam int N_REGS = 9;
   localparam int IDX_W  = $clog2(N_REGS);

   // storage slot of each mapped register
   localparam int SLOT_ULOCAL  = 0;
   localparam int SLOT_BADADDR = 1;
   localparam int SLOT_TICKS   = 2;
   localparam int SLOT_MATCH   = 3;
   localparam int SLOT_STATE   = 4;
   localparam int SLOT_REASON  = 5;
   localparam int SLOT_RESUME  = 6;
   localparam int SLOT_VECBASE = 7;
   localparam int SLOT_SETUP   = 8;

   typedef enum logic [2:0] {
      XOP_NONE,
      XOP_READ,
      XOP_WRITE,
      XOP_RMW,
      XOP_RETURN
   } xop_e;

   typedef struct packed {
      logic             hit;
      logic [IDX_W-1:0] slot;
   } map_res_t;

   // sparse (number, select) lookup
   function automatic map_res_t map_lookup(input logic [4:0] num, input logic [2:0] sel);
      map_res_t r;
      r.hit  = 1'b1;
      r.slot = '0;
      case ({num, sel})
         {5'd4,  3'd2}: r.slot = IDX_W'(SLOT_ULOCAL);
         {5'd8,  3'd0}: r.slot = IDX_W'(SLOT_BADADDR);
         {5'd9,  3'd0}: r.slot = IDX_W'(SLOT_TICKS);
         {5'd11, 3'd0}: r.slot = IDX_W'(SLOT_MATCH);
         {5'd12, 3'd0}: r.slot = IDX_W'(SLOT_STATE);
         {5'd13, 3'd0}: r.slot = IDX_W'(SLOT_REASON);
         {5'd14, 3'd0}: r.slot = IDX_W'(SLOT_RESUME);
         {5'd15, 3'd1}: r.slot = IDX_W'(SLOT_VECBASE);
         {5'd16, 3'd0}: r.slot = IDX_W'(SLOT_SETUP);
         default:       r.hit  = 1'b0;
      endcase
      return r;
   endfunction

   // software-writable bits of each slot
   function automatic logic [31:0] slot_mask(input int slot);
      case (slot)
         SLOT_ULOCAL:  return 32'hFFFF_FFFF;
         SLOT_RESUME:  return 32'hFFFF_FFFF;
         SLOT_VECBASE: return 32'hFFFF_FFFC;
         default:      return 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/xcb_decode.sv
module xcb_decode
   import xcb_pkg::*;
#(
   parameter int INSTR_W  = 32,
   parameter int OPC_COP  = 16,
   parameter int SUB_READ = 0,
   parameter int SUB_WRITE = 4,
   parameter int SUB_RMW  = 11,
   parameter int FN_RETURN = 24
) (
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr,
   output xop_e               op,
   output logic [4:0]         reg_num,
   output logic [2:0]         reg_sel,
   output logic               force_one
);
   logic [5:0] opcode;
   logic [4:0] sub;
   logic [5:0] fn;
   logic       unused_fields;

   assign opcode    = instr[31:26];
   assign sub       = instr[25:21];
   assign fn        = instr[5:0];
   assign reg_num   = instr[15:11];
   assign reg_sel   = instr[2:0];
   assign force_one = instr[5];
   assign unused_fields = ^{instr[20:16], instr[10:6]};

   always_comb begin
      op = XOP_NONE;
      if (instr_valid && opcode == 6'(OPC_COP)) begin
         if (sub[4]) begin
            if (fn == 6'(FN_RETURN)) op = XOP_RETURN;
         end else if (sub == 5'(SUB_READ)) begin
            op = XOP_READ;
         end else if (sub == 5'(SUB_WRITE)) begin
            op = XOP_WRITE;
         end else if (sub == 5'(SUB_RMW)) begin
            op = XOP_RMW;
         end
      end
   end
endmodule

// File: rtl/xcb_regmap.sv
module xcb_regmap
   import xcb_pkg::*;
(
   input  logic [4:0]       reg_num,
   input  logic [2:0]       reg_sel,
   output logic             hit,
   output logic [IDX_W-1:0] slot
);
   map_res_t res;

   assign res  = map_lookup(reg_num, reg_sel);
   assign hit  = res.hit;
   assign slot = res.slot;
endmodule

// File: rtl/xcb_regfile.sv
module xcb_regfile
   import xcb_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CODE_W   = 5,
   parameter int CODE_LSB = 2,
   parameter int CLR_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_slot,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_slot,
   output logic [DATA_W-1:0] rd_value,
   input  logic              exc_valid,
   input  logic [CODE_W-1:0] exc_code,
   input  logic              exc_in_slot,
   input  logic [DATA_W-1:0] exc_pc,
   input  logic [DATA_W-1:0] exc_branch_pc,
   output logic [DATA_W-1:0] resume_q,
   output logic [DATA_W-1:0] reason_q
);
   logic [DATA_W-1:0] q [N_REGS];

   for (genvar g = 0; g < N_REGS; g++) begin : g_slot
      localparam logic [DATA_W-1:0] MASK = DATA_W'(slot_mask(g));
      logic              sw_hit;
      logic [DATA_W-1:0] sw_next;

      assign sw_hit  = wr_en && (wr_slot == IDX_W'(g));
      assign sw_next = (wr_data & MASK) | (q[g] & ~MASK);

      if (g == SLOT_RESUME) begin : g_resume
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q[g] <= '0;
            else if (exc_valid) q[g] <= exc_in_slot ? exc_branch_pc : exc_pc;
            else if (sw_hit)    q[g] <= sw_next;
         end
      end else if (g == SLOT_REASON) begin : g_reason
         logic [DATA_W-1:0] exc_next;
         always_comb begin
            exc_next = q[g];
            exc_next[DATA_W-1] = exc_in_slot;
            exc_next[CLR_W-1:0] = '0;
            if (exc_code != '0) exc_next[CODE_LSB +: CODE_W] = exc_code;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q[g] <= '0;
            else if (exc_valid) q[g] <= exc_next;
            else if (sw_hit)    q[g] <= sw_next;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[g] <= '0;
            else if (sw_hit) q[g] <= sw_next;
         end
      end
   end

   always_comb begin
      rd_value = '0;
      for (int i = 0; i < N_REGS; i++)
         if (rd_slot == IDX_W'(i)) rd_value = q[i];
   end

   assign resume_q = q[SLOT_RESUME];
   assign reason_q = q[SLOT_REASON];
endmodule

// File: rtl/exc_ctrl_bank.sv
module exc_ctrl_bank
   import xcb_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CODE_W   = 5,
   parameter int CODE_LSB = 2,
   parameter int CLR_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [31:0]       instr,
   input  logic [DATA_W-1:0] src_operand,
   input  logic              exc_valid,
   input  logic [CODE_W-1:0] exc_code,
   input  logic              exc_in_slot,
   input  logic [DATA_W-1:0] exc_pc,
   input  logic [DATA_W-1:0] exc_branch_pc,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              fault,
   output logic              redirect_valid,
   output logic [DATA_W-1:0] redirect_pc
);
   if (DATA_W != 32) begin : g_bad_width
      $error("exc_ctrl_bank: DATA_W must be 32");
   end
   if (CODE_LSB + CODE_W > CLR_W) begin : g_bad_code
      $error("exc_ctrl_bank: cause code field exceeds cleared range");
   end

   xop_e              op;
   logic [4:0]        reg_num;
   logic [2:0]        reg_sel;
   logic              force_one;
   logic              hit;
   logic [IDX_W-1:0]  slot;
   logic              is_access;
   logic              is_readback;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_value;
   logic [DATA_W-1:0] resume_q;
   logic [DATA_W-1:0] reason_q;

   xcb_decode u_decode (
      .instr_valid (instr_valid),
      .instr       (instr),
      .op          (op),
      .reg_num     (reg_num),
      .reg_sel     (reg_sel),
      .force_one   (force_one)
   );

   xcb_regmap u_map (
      .reg_num (reg_num),
      .reg_sel (reg_sel),
      .hit     (hit),
      .slot    (slot)
   );

   assign is_access   = (op == XOP_READ) || (op == XOP_WRITE) || (op == XOP_RMW);
   assign is_readback = hit && ((op == XOP_READ) || (op == XOP_RMW));
   assign wr_en       = hit && ((op == XOP_WRITE) || (op == XOP_RMW));
   assign wr_data     = (op == XOP_RMW) ? {src_operand[DATA_W-1:1], force_one} : src_operand;

   xcb_regfile #(
      .DATA_W   (DATA_W),
      .CODE_W   (CODE_W),
      .CODE_LSB (CODE_LSB),
      .CLR_W    (CLR_W)
   ) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .wr_slot       (slot),
      .wr_data       (wr_data),
      .rd_slot       (slot),
      .rd_value      (rd_value),
      .exc_valid     (exc_valid),
      .exc_code      (exc_code),
      .exc_in_slot   (exc_in_slot),
      .exc_pc        (exc_pc),
      .exc_branch_pc (exc_branch_pc),
      .resume_q      (resume_q),
      .reason_q      (reason_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid       <= 1'b0;
         rd_data        <= '0;
         fault          <= 1'b0;
         redirect_valid <= 1'b0;
         redirect_pc    <= '0;
      end else begin
         rd_valid       <= is_readback;
         rd_data        <= is_readback ? rd_value : '0;
         fault          <= is_access && !hit;
         redirect_valid <= (op == XOP_RETURN);
         redirect_pc    <= (op == XOP_RETURN) ? resume_q : '0;
      end
   end
endmodule

// File: rtl/xcb_checker.sv
module xcb_checker #(
   parameter int DATA_W = 32,
   parameter int CODE_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid,
   input logic              exc_valid,
   input logic [CODE_W-1:0] exc_code,
   input logic              exc_in_slot,
   input logic [DATA_W-1:0] exc_pc,
   input logic [DATA_W-1:0] exc_branch_pc,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              fault,
   input logic              redirect_valid,
   input logic [DATA_W-1:0] redirect_pc,
   input logic [DATA_W-1:0] resume_q,
   input logic [DATA_W-1:0] reason_q
);
   AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (rd_data == '0 && !rd_valid)); // R4

   AST_OUTPUTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_valid, fault, redirect_valid})); // R4

   AST_EPC_FROM_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exc_in_slot) |=> resume_q == $past(exc_branch_pc)); // R6

   AST_EPC_FROM_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && !exc_in_slot) |=> resume_q == $past(exc_pc)); // R6

   AST_CAUSE_SLOT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> (reason_q[DATA_W-1] == $past(exc_in_slot) && reason_q[1:0] == 2'b00)); // R7

   AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> reason_q[6:2] == $past(exc_code)); // R7

   AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> redirect_pc == $past(resume_q)); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> (!rd_valid && !fault && !redirect_valid)); // R10
endmodule

bind exc_ctrl_bank xcb_checker #(
   .DATA_W (DATA_W),
   .CODE_W (CODE_W)
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .instr_valid    (instr_valid),
   .exc_valid      (exc_valid),
   .exc_code       (exc_code),
   .exc_in_slot    (exc_in_slot),
   .exc_pc         (exc_pc),
   .exc_branch_pc  (exc_branch_pc),
   .rd_valid       (rd_valid),
   .rd_data        (rd_data),
   .fault          (fault),
   .redirect_valid (redirect_valid),
   .redirect_pc    (redirect_pc),
   .resume_q       (resume_q),
   .reason_q       (reason_q)
);

// File: tb/exc_ctrl_bank_tb_top.sv
module exc_ctrl_bank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] src_operand = '0;
   logic        exc_valid = 1'b0;
   logic [4:0]  exc_code = '0;
   logic        exc_in_slot = 1'b0;
   logic [31:0] exc_pc = '0;
   logic [31:0] exc_branch_pc = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        fault;
   logic        redirect_valid;
   logic [31:0] redirect_pc;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;

   always #5 clk = ~clk;

   exc_ctrl_bank dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .instr_valid    (instr_valid),
      .instr          (instr),
      .src_operand    (src_operand),
      .exc_valid      (exc_valid),
      .exc_code       (exc_code),
      .exc_in_slot    (exc_in_slot),
      .exc_pc         (exc_pc),
      .exc_branch_pc  (exc_branch_pc),
      .rd_valid       (rd_valid),
      .rd_data        (rd_data),
      .fault          (fault),
      .redirect_valid (redirect_valid),
      .redirect_pc    (redirect_pc)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] cop(input logic [4:0] sub, input logic [4:0] num,
                                      input logic [2:0] sel, input logic [2:0] fhi);
      return {6'd16, sub, 5'd0, num, 5'd0, fhi, sel};
   endfunction

   // present one word; outputs are sampled at the following falling edge
   task automatic issue(input logic [31:0] w, input logic [31:0] src);
      @(negedge clk);
      instr_valid = 1'b1;
      instr       = w;
      src_operand = src;
      @(negedge clk);
      instr_valid = 1'b0;
      instr       = '0;
      src_operand = '0;
   endtask

   task automatic wr(input logic [4:0] num, input logic [2:0] sel, input logic [31:0] v);
      issue(cop(5'd4, num, sel, 3'd0), v);
   endtask

   task automatic rd_chk(input string tag, input logic [4:0] num, input logic [2:0] sel,
                         input logic [31:0] exp);
      issue(cop(5'd0, num, sel, 3'd0), 32'h0);
      chk({tag, " valid"}, {31'd0, rd_valid}, 32'd1);
      chk({tag, " data"}, rd_data, exp);
   endtask

   task automatic raise(input logic [4:0] code, input logic slot,
                        input logic [31:0] pc, input logic [31:0] bpc);
      @(negedge clk);
      exc_valid = 1'b1; exc_code = code; exc_in_slot = slot;
      exc_pc = pc; exc_branch_pc = bpc;
      @(negedge clk);
      exc_valid = 1'b0; exc_code = '0; exc_in_slot = 1'b0;
      exc_pc = '0; exc_branch_pc = '0;
   endtask

   task automatic t_reset;
      chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
      chk("R1 fault", {31'd0, fault}, 32'd0);
      chk("R1 redirect", {31'd0, redirect_valid}, 32'd0);
      chk("R1 redirect_pc", redirect_pc, 32'd0);
      rd_chk("R1 epc", 5'd14, 3'd0, 32'd0);
      rd_chk("R1 ebase", 5'd15, 3'd1, 32'd0);
      rd_chk("R1 ulocal", 5'd4, 3'd2, 32'd0);
   endtask

   task automatic t_masks;
      wr(5'd4, 3'd2, 32'hFFFF_FFFF);
      rd_chk("R3 ulocal full", 5'd4, 3'd2, 32'hFFFF_FFFF);
      wr(5'd14, 3'd0, 32'h1234_5678);
      rd_chk("R2 epc readback", 5'd14, 3'd0, 32'h1234_5678);
      wr(5'd15, 3'd1, 32'hFFFF_FFFF);
      rd_chk("R3 ebase mask", 5'd15, 3'd1, 32'hFFFF_FFFC);
      wr(5'd15, 3'd1, 32'h0000_0003);
      rd_chk("R3 ebase low bits", 5'd15, 3'd1, 32'h0000_0000);
      wr(5'd12, 3'd0, 32'hDEAD_BEEF);
      rd_chk("R3 status frozen", 5'd12, 3'd0, 32'h0);
      wr(5'd16, 3'd0, 32'hFFFF_FFFF);
      rd_chk("R3 config frozen", 5'd16, 3'd0, 32'h0);
   endtask

   task automatic t_unmapped;
      issue(cop(5'd4, 5'd14, 3'd1, 3'd0), 32'hAAAA_AAAA);
      chk("R4 write fault", {31'd0, fault}, 32'd1);
      @(negedge clk);
      chk("R4 fault one cycle", {31'd0, fault}, 32'd0);
      rd_chk("R4 epc untouched", 5'd14, 3'd0, 32'h1234_5678);
      issue(cop(5'd0, 5'd15, 3'd0, 3'd0), 32'h0);
      chk("R4 read fault", {31'd0, fault}, 32'd1);
      chk("R4 read data", rd_data, 32'h0);
      chk("R4 read valid", {31'd0, rd_valid}, 32'd0);
      issue(cop(5'd11, 5'd4, 3'd0, 3'd4), 32'h5);
      chk("R4 rmw fault", {31'd0, fault}, 32'd1);
      rd_chk("R4 ulocal untouched", 5'd4, 3'd2, 32'hFFFF_FFFF);
   endtask

   task automatic t_rmw;
      issue(cop(5'd11, 5'd4, 3'd2, 3'd0), 32'h0F0F_0F0F);
      chk("R5 clear returns old", rd_data, 32'hFFFF_FFFF);
      rd_chk("R5 clear bit0", 5'd4, 3'd2, 32'h0F0F_0F0E);
      issue(cop(5'd11, 5'd4, 3'd2, 3'd4), 32'h0000_0010);
      chk("R5 set returns old", rd_data, 32'h0F0F_0F0E);
      rd_chk("R5 set bit0", 5'd4, 3'd2, 32'h0000_0011);
      issue(cop(5'd11, 5'd15, 3'd1, 3'd4), 32'h0000_0040);
      rd_chk("R5 ebase mask on rmw", 5'd15, 3'd1, 32'h0000_0040);
   endtask

   task automatic t_exc;
      raise(5'd4, 1'b0, 32'h0000_0400, 32'h0000_03FC);
      rd_chk("R6 epc direct", 5'd14, 3'd0, 32'h0000_0400);
      rd_chk("R7 cause code", 5'd13, 3'd0, 32'h0000_0010);
      raise(5'd31, 1'b1, 32'h0000_0804, 32'h0000_0800);
      rd_chk("R6 epc branch", 5'd14, 3'd0, 32'h0000_0800);
      rd_chk("R7 cause slot", 5'd13, 3'd0, 32'h8000_007C);
      raise(5'd0, 1'b0, 32'h0000_0900, 32'h0000_08FC);
      rd_chk("R7 interrupt clears", 5'd13, 3'd0, 32'h0000_0000);
   endtask

   task automatic t_return;
      wr(5'd14, 3'd0, 32'hBFC0_0180);
      issue(cop(5'd16, 5'd0, 3'd0, 3'd3), 32'h0);
      chk("R8 redirect valid", {31'd0, redirect_valid}, 32'd1);
      chk("R8 redirect pc", redirect_pc, 32'hBFC0_0180);
      @(negedge clk);
      chk("R8 redirect pulse", {31'd0, redirect_valid}, 32'd0);
   endtask

   task automatic t_collide;
      @(negedge clk);
      instr_valid = 1'b1; instr = cop(5'd4, 5'd14, 3'd0, 3'd0); src_operand = 32'h5555_0000;
      exc_valid = 1'b1; exc_code = 5'd2; exc_in_slot = 1'b0;
      exc_pc = 32'h0000_7000; exc_branch_pc = 32'h0000_6FFC;
      @(negedge clk);
      instr_valid = 1'b0; instr = '0; src_operand = '0;
      exc_valid = 1'b0; exc_code = '0; exc_pc = '0; exc_branch_pc = '0;
      rd_chk("R9 exception wins", 5'd14, 3'd0, 32'h0000_7000);
   endtask

   task automatic t_ignore;
      issue({6'd0, 5'd4, 5'd0, 5'd14, 5'd0, 6'd0}, 32'h1111_1111);
      chk("R10 other opcode quiet", {29'd0, rd_valid, fault, redirect_valid}, 32'd0);
      @(negedge clk);
      instr = cop(5'd4, 5'd14, 3'd0, 3'd0); src_operand = 32'h2222_2222;
      @(negedge clk);
      instr = '0; src_operand = '0;
      chk("R10 invalid quiet", {29'd0, rd_valid, fault, redirect_valid}, 32'd0);
      issue(cop(5'd16, 5'd0, 3'd1, 3'd3), 32'h0);
      chk("R10 other function", {31'd0, redirect_valid}, 32'd0);
      issue(cop(5'd1, 5'd14, 3'd0, 3'd0), 32'h3333_3333);
      chk("R10 other sub-op", {29'd0, rd_valid, fault, redirect_valid}, 32'd0);
      rd_chk("R10 epc unchanged", 5'd14, 3'd0, 32'h0000_7000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_masks();
      t_unmapped();
      t_rmw();
      t_exc();
      t_return();
      t_collide();
      t_ignore();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule